// File: doc/BRIEF.md
# Command Mailbox Register Block

This block sits on the device side of a command mailbox between a host and a command executor. The host uses a plain register port to write a command word (opcode and payload length) and payload bytes. It then sets a doorbell bit. On the cycle the doorbell rises, the block gives the executor a single start pulse together with the opcode and the input length. The executor may read the payload RAM and write into it while the doorbell is set. It finishes with a done pulse that carries a return code and an output length.

When the doorbell clears, all mailbox state is frozen: the command word, the status and the payload RAM stay exactly as they were until the host rings again. The payload RAM size is a power-of-two parameter. Its log2, capped at 20, is reported in a read-only capability register. A device-status register carries a mailbox-ready flag, which gates completion, and three health indications. The upper byte of the opcode names a command group and the lower byte a command within it. The block passes the opcode through unchanged.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, the doorbell (control offset 0x04, bit 0), the opcode (offset 0x08, bits 15:0), the length (offset 0x0C, bits 20:0) and the return code (offset 0x10, bits 15:0) all read zero and the start pulse is low. The capability register (offset 0x00, bits 4:0) reads log2 of the payload RAM size, capped at 20, which is 8 for the default of 256 bytes.
- R2: While the doorbell is clear, the host may write the opcode, the length and payload bytes in any order, and each reads back as written. A payload byte sits at register address PAYLOAD_BYTES + index, which is 0x100 + index for the default size, with the data in bits 7:0.
- R3: Writing 1 to control bit 0 while the doorbell is clear sets the doorbell. The start pulse is high for exactly one cycle, the first cycle in which the doorbell reads 1, and the opcode and input length appear on the backend outputs. Writing 1 again while the doorbell is set gives no further pulse.
- R4: While the doorbell is set, host writes to the opcode, the length and the payload window are ignored, and writing 0 to the control register leaves the doorbell set.
- R5: The doorbell clears only on a backend done pulse while the doorbell is set and the mailbox-ready input is high. On that edge, the return code goes into the status register and the output length replaces the length field.
- R6: While the doorbell is clear, backend done pulses and backend payload writes have no effect on the status, the length or the payload RAM.
- R7: While the doorbell is set, backend payload writes store into the RAM, and the backend read port returns RAM contents combinationally.
- R8: The device-status register (offset 0x14) reads ready in bit 0, fatal in bit 1, firmware-halted in bit 2 and reset-needed in bits 4:3. A done pulse arriving while ready is low leaves the doorbell set.
- R9: Host writes to the capability, status and device-status registers have no effect.
- R10: When a backend done pulse and a host write to the length register fall in the same cycle, the host write is dropped and the output length from the backend is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Host register write strobe |
| regAddr | input | log2(PAYLOAD_BYTES)+1 | Host byte address; the top bit selects the payload window |
| regWdata | input | 21 | Host write data |
| regRdata | output | 21 | Host read data for regAddr (combinational) |
| beStart | output | 1 | One-cycle command start pulse to the executor |
| beOpcode | output | 16 | Current opcode |
| beInLen | output | 21 | Current length field |
| beMemAddr | input | log2(PAYLOAD_BYTES) | Executor payload byte address |
| beMemWe | input | 1 | Executor payload write strobe |
| beMemWdata | input | 8 | Executor payload write byte |
| beMemRdata | output | 8 | Payload byte at beMemAddr |
| beDone | input | 1 | Executor completion pulse |
| beRetCode | input | 16 | Return code for the completion, where zero means success |
| beOutLen | input | 21 | Output length for the completion |
| devReady | input | 1 | Mailbox interface ready |
| devFatal | input | 1 | Device fatal indication |
| fwHalted | input | 1 | Firmware halted indication |
| resetNeeded | input | 2 | Reset-needed indication |

## Verification
The two functions that can meet in one cycle are the executor's completion and a host write to the command length. The bench drives a done pulse in the same cycle as a host write of a different length. It then expects to read back the executor's output length with the doorbell cleared, which shows that the write was judged against the doorbell still set at that edge. The same timing is used to pair a completion that arrives after the doorbell has cleared with an executor payload write, and the status and payload bytes are then expected to be unchanged.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;

  localparam int OPC_W  = 16;
  localparam int LEN_W  = 21;
  localparam int RET_W  = 16;
  localparam int DATA_W = LEN_W;   // register port as wide as the widest field
  localparam int EXP_W  = 5;
  localparam int EXP_MAX = 20;     // 1 MiB advertised ceiling

  localparam int OFS_CAP  = 'h00;
  localparam int OFS_CTRL = 'h04;
  localparam int OFS_OPC  = 'h08;
  localparam int OFS_LEN  = 'h0C;
  localparam int OFS_STAT = 'h10;
  localparam int OFS_DEV  = 'h14;

  typedef struct packed {
    logic opcWe;     // host opcode write accepted
    logic lenWe;     // host length write accepted
    logic payWe;     // host payload byte write accepted
    logic beWe;      // executor payload write accepted
    logic doneTake;  // completion accepted this edge
  } mbStrobe_t;

  function automatic int capExp(input int bytes);
    int e;
    e = $clog2(bytes);
    return (e > EXP_MAX) ? EXP_MAX : e;
  endfunction

endpackage

// File: rtl/cmd_mailbox_ctrl.sv
module cmd_mailbox_ctrl
  import cmd_mailbox_pkg::*;
#(
  parameter int PAY_AW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [PAY_AW:0] regAddr,
  input  logic            ctrlBit,
  input  logic            beMemWe,
  input  logic            beDone,
  input  logic            devReady,
  output mbStrobe_t       stb,
  output logic            doorbell,
  output logic            beStart
);

  logic              isReg;
  logic [PAY_AW-1:0] low;
  logic              hostIdle;
  logic              ringReq;

  assign isReg    = ~regAddr[PAY_AW];
  assign low      = regAddr[PAY_AW-1:0];
  assign hostIdle = ~doorbell;

  always_comb begin
    stb.opcWe    = regWe && hostIdle && isReg && (low == PAY_AW'(OFS_OPC));
    stb.lenWe    = regWe && hostIdle && isReg && (low == PAY_AW'(OFS_LEN));
    stb.payWe    = regWe && hostIdle && regAddr[PAY_AW];
    stb.beWe     = beMemWe && doorbell;
    stb.doneTake = beDone && devReady && doorbell;
  end

  assign ringReq = regWe && isReg && (low == PAY_AW'(OFS_CTRL)) && ctrlBit && hostIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doorbell <= 1'b0;
      beStart  <= 1'b0;
    end else begin
      beStart <= ringReq;
      if (ringReq)           doorbell <= 1'b1;
      else if (stb.doneTake) doorbell <= 1'b0;
    end
  end

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    beStart |=> !beStart);

  assert_start_on_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doorbell) |-> beStart);

  assert_clear_by_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doorbell) |-> $past(beDone && devReady));

  assert_ready_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (doorbell && !devReady) |=> doorbell);

endmodule

// File: rtl/cmd_mailbox_dp.sv
module cmd_mailbox_dp
  import cmd_mailbox_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 256,
  parameter int PAY_AW        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbStrobe_t         stb,
  input  logic              doorbell,
  input  logic [PAY_AW:0]   regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [PAY_AW-1:0] beMemAddr,
  input  logic [7:0]        beMemWdata,
  output logic [7:0]        beMemRdata,
  input  logic [RET_W-1:0]  beRetCode,
  input  logic [LEN_W-1:0]  beOutLen,
  input  logic              devReady,
  input  logic              devFatal,
  input  logic              fwHalted,
  input  logic [1:0]        resetNeeded,
  output logic [OPC_W-1:0]  cmdOpcode,
  output logic [LEN_W-1:0]  cmdLen
);

  localparam int ADV_EXP = capExp(PAYLOAD_BYTES);
  localparam logic [EXP_W-1:0] ADV_EXP_V = EXP_W'(ADV_EXP);

  logic [7:0]       payMem [PAYLOAD_BYTES];
  logic [RET_W-1:0] retCode;
  logic [PAY_AW-1:0] low;

  assign low = regAddr[PAY_AW-1:0];

  always_ff @(posedge clk) begin
    if (stb.payWe)      payMem[low]       <= regWdata[7:0];
    else if (stb.beWe)  payMem[beMemAddr] <= beMemWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOpcode <= '0;
      cmdLen    <= '0;
      retCode   <= '0;
    end else begin
      if (stb.opcWe) cmdOpcode <= regWdata[OPC_W-1:0];
      if (stb.doneTake) begin
        cmdLen  <= beOutLen;
        retCode <= beRetCode;
      end else if (stb.lenWe) begin
        cmdLen <= regWdata[LEN_W-1:0];
      end
    end
  end

  assign beMemRdata = payMem[beMemAddr];

  always_comb begin
    regRdata = '0;
    if (regAddr[PAY_AW]) begin
      regRdata[7:0] = payMem[low];
    end else begin
      unique case (low)
        PAY_AW'(OFS_CAP):  regRdata[EXP_W-1:0] = ADV_EXP_V;
        PAY_AW'(OFS_CTRL): regRdata[0]         = doorbell;
        PAY_AW'(OFS_OPC):  regRdata[OPC_W-1:0] = cmdOpcode;
        PAY_AW'(OFS_LEN):  regRdata[LEN_W-1:0] = cmdLen;
        PAY_AW'(OFS_STAT): regRdata[RET_W-1:0] = retCode;
        PAY_AW'(OFS_DEV):  regRdata[4:0]       = {resetNeeded, fwHalted, devFatal, devReady};
        default:           regRdata            = '0;
      endcase
    end
  end

  assert_opc_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (doorbell && $past(doorbell)) |-> $stable(cmdOpcode));

  assert_len_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (doorbell && $past(doorbell)) |-> $stable(cmdLen));

  assert_ret_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!doorbell && $past(!doorbell)) |-> $stable(retCode));

  assert_status_on_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doorbell) |-> (retCode == $past(beRetCode)));

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmd_mailbox_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 256
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               regWe,
  input  logic [$clog2(PAYLOAD_BYTES):0]     regAddr,
  input  logic [20:0]                        regWdata,
  output logic [20:0]                        regRdata,
  output logic                               beStart,
  output logic [15:0]                        beOpcode,
  output logic [20:0]                        beInLen,
  input  logic [$clog2(PAYLOAD_BYTES)-1:0]   beMemAddr,
  input  logic                               beMemWe,
  input  logic [7:0]                         beMemWdata,
  output logic [7:0]                         beMemRdata,
  input  logic                               beDone,
  input  logic [15:0]                        beRetCode,
  input  logic [20:0]                        beOutLen,
  input  logic                               devReady,
  input  logic                               devFatal,
  input  logic                               fwHalted,
  input  logic [1:0]                         resetNeeded
);

  localparam int PAY_AW = $clog2(PAYLOAD_BYTES);

  generate
    if (PAYLOAD_BYTES < 256 || (1 << PAY_AW) != PAYLOAD_BYTES) begin : g_badSize
      $error("payload RAM must be a power of two of at least 256 bytes");
    end
  endgenerate

  mbStrobe_t stb;
  logic      doorbell;

  cmd_mailbox_ctrl #(.PAY_AW(PAY_AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .ctrlBit  (regWdata[0]),
    .beMemWe  (beMemWe),
    .beDone   (beDone),
    .devReady (devReady),
    .stb      (stb),
    .doorbell (doorbell),
    .beStart  (beStart)
  );

  cmd_mailbox_dp #(.PAYLOAD_BYTES(PAYLOAD_BYTES), .PAY_AW(PAY_AW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .doorbell    (doorbell),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .beMemAddr   (beMemAddr),
    .beMemWdata  (beMemWdata),
    .beMemRdata  (beMemRdata),
    .beRetCode   (beRetCode),
    .beOutLen    (beOutLen),
    .devReady    (devReady),
    .devFatal    (devFatal),
    .fwHalted    (fwHalted),
    .resetNeeded (resetNeeded),
    .cmdOpcode   (beOpcode),
    .cmdLen      (beInLen)
  );

endmodule

// File: tb/cmd_mailbox_tb.sv
`timescale 1ns/1ps
module cmd_mailbox_tb;

  localparam logic [8:0] A_CAP = 9'h000, A_CTRL = 9'h004, A_OPC = 9'h008,
                         A_LEN = 9'h00C, A_STAT = 9'h010, A_DEV = 9'h014,
                         A_PAY = 9'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [20:0] regWdata = '0;
  logic [20:0] regRdata;
  logic        beStart;
  logic [15:0] beOpcode;
  logic [20:0] beInLen;
  logic [7:0]  beMemAddr = '0;
  logic        beMemWe = 1'b0;
  logic [7:0]  beMemWdata = '0;
  logic [7:0]  beMemRdata;
  logic        beDone = 1'b0;
  logic [15:0] beRetCode = '0;
  logic [20:0] beOutLen = '0;
  logic        devReady = 1'b1;
  logic        devFatal = 1'b0;
  logic        fwHalted = 1'b0;
  logic [1:0]  resetNeeded = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cmd_mailbox #(.PAYLOAD_BYTES(256)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .beStart(beStart), .beOpcode(beOpcode), .beInLen(beInLen),
    .beMemAddr(beMemAddr), .beMemWe(beMemWe), .beMemWdata(beMemWdata),
    .beMemRdata(beMemRdata), .beDone(beDone), .beRetCode(beRetCode),
    .beOutLen(beOutLen), .devReady(devReady), .devFatal(devFatal),
    .fwHalted(fwHalted), .resetNeeded(resetNeeded)
  );

  // Behavioural reference model
  bit          mBusy;
  bit          mStart;
  logic [15:0] mOpc;
  logic [20:0] mLen;
  logic [15:0] mRet;
  logic [7:0]  mMem [int];

  always @(posedge clk) begin
    bit wasBusy;
    if (!rstN) begin
      mBusy = 0; mStart = 0; mOpc = '0; mLen = '0; mRet = '0;
    end else begin
      wasBusy = mBusy;
      mStart = 0;
      if (regWe && !wasBusy) begin
        if (regAddr == A_OPC) mOpc = regWdata[15:0];
        if (regAddr == A_LEN) mLen = regWdata;
        if (regAddr[8])       mMem[int'(regAddr[7:0])] = regWdata[7:0];
        if (regAddr == A_CTRL && regWdata[0]) begin mBusy = 1; mStart = 1; end
      end
      if (wasBusy && beMemWe) mMem[int'(beMemAddr)] = beMemWdata;
      if (wasBusy && beDone && devReady) begin
        mBusy = 0; mRet = beRetCode; mLen = beOutLen;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R3 backend outputs)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R3", {15'b0, beStart, beOpcode}, {15'b0, mStart, mOpc}, "start/opcode per cycle");
      chk("R3", {11'b0, beInLen}, {11'b0, mLen}, "length per cycle");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [8:0] a, input logic [20:0] d);
    @(negedge clk); #0.5;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); #0.5;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [20:0] exp, input string req, input string what);
    regAddr = a;
    @(negedge clk);
    chk(req, {11'b0, regRdata}, {11'b0, exp}, what);
    #0.5;
  endtask

  // one cycle of executor activity, optionally with a host write in the same cycle
  task automatic beCycle(input bit dn, input logic [15:0] ret, input logic [20:0] olen,
                         input bit mw, input logic [7:0] ma, input logic [7:0] md,
                         input bit hw, input logic [8:0] ha, input logic [20:0] hd);
    @(negedge clk); #0.5;
    beDone = dn; beRetCode = ret; beOutLen = olen;
    beMemWe = mw; beMemAddr = ma; beMemWdata = md;
    regWe = hw; regAddr = ha; regWdata = hd;
    @(negedge clk); #0.5;
    beDone = 1'b0; beMemWe = 1'b0; regWe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5 rstN = 1'b1;

    // R1 reset state
    rd(A_CAP,  21'd8, "R1", "capability exponent");
    rd(A_CTRL, 21'd0, "R1", "doorbell after reset");
    rd(A_OPC,  21'd0, "R1", "opcode after reset");
    rd(A_LEN,  21'd0, "R1", "length after reset");
    rd(A_STAT, 21'd0, "R1", "status after reset");
    rd(A_DEV,  21'd1, "R8", "device status ready only");

    // R9 read-only registers
    wr(A_CAP, 21'h1F); wr(A_STAT, 21'hFFFF); wr(A_DEV, 21'h1E);
    rd(A_CAP,  21'd8, "R9", "capability after write");
    rd(A_STAT, 21'd0, "R9", "status after write");
    rd(A_DEV,  21'd1, "R9", "device status after write");

    // R4 writing zero to control while idle does nothing
    wr(A_CTRL, 21'd0);
    rd(A_CTRL, 21'd0, "R4", "control zero write");

    // R2 any-order setup
    wr(A_PAY + 9'd2, 21'h3C);
    wr(A_LEN, 21'h000010);
    wr(A_PAY + 9'd0, 21'hC1);
    wr(A_OPC, 21'h1F4200);
    rd(A_OPC, 21'h4200, "R2", "opcode readback");
    rd(A_LEN, 21'h10, "R2", "length readback");
    rd(A_PAY + 9'd0, 21'hC1, "R2", "payload byte 0");
    rd(A_PAY + 9'd2, 21'h3C, "R2", "payload byte 2");

    // R3 ring doorbell
    @(negedge clk); #0.5;
    regWe = 1'b1; regAddr = A_CTRL; regWdata = 21'd1;
    @(negedge clk);
    chk("R3", {31'b0, beStart}, 32'd1, "start pulse after ring");
    chk("R3", {16'b0, beOpcode}, 32'h4200, "backend opcode");
    chk("R3", {11'b0, beInLen}, 32'h10, "backend input length");
    #0.5 regWe = 1'b0;
    @(negedge clk);
    chk("R3", {31'b0, beStart}, 32'd0, "start pulse width");
    #0.5;
    rd(A_CTRL, 21'd1, "R3", "doorbell set");
    wr(A_CTRL, 21'd1);   // second ring: per-cycle compare expects no pulse (R3)

    // R4 host writes ignored while busy
    wr(A_OPC, 21'h1111); wr(A_LEN, 21'h5); wr(A_PAY + 9'd0, 21'h99); wr(A_CTRL, 21'd0);
    rd(A_OPC, 21'h4200, "R4", "opcode frozen while busy");
    rd(A_LEN, 21'h10, "R4", "length frozen while busy");
    rd(A_PAY + 9'd0, 21'hC1, "R4", "payload frozen while busy");
    rd(A_CTRL, 21'd1, "R4", "doorbell survives zero write");

    // R7 executor payload access
    beCycle(1'b0, 16'h0, 21'h0, 1'b1, 8'd5, 8'hA5, 1'b0, 9'h0, 21'h0);
    rd(A_PAY + 9'd5, 21'hA5, "R7", "executor write landed");
    beMemAddr = 8'd2;
    @(negedge clk);
    chk("R7", {24'b0, beMemRdata}, 32'h3C, "executor read port");
    #0.5;

    // R8 completion gated by ready
    devReady = 1'b0;
    beCycle(1'b1, 16'h7, 21'h1, 1'b0, 8'd0, 8'h0, 1'b0, 9'h0, 21'h0);
    rd(A_CTRL, 21'd1, "R8", "doorbell held while not ready");
    rd(A_STAT, 21'd0, "R8", "status held while not ready");
    devReady = 1'b1;

    // R5 / R10 completion colliding with a host length write
    beCycle(1'b1, 16'h3, 21'h40, 1'b0, 8'd0, 8'h0, 1'b1, A_LEN, 21'h77);
    rd(A_CTRL, 21'd0, "R5", "doorbell cleared by done");
    rd(A_STAT, 21'h3, "R5", "return code latched");
    rd(A_LEN, 21'h40, "R10", "backend length wins collision");
    rd(A_OPC, 21'h4200, "R5", "opcode kept at completion");

    // R6 frozen after clear
    beCycle(1'b1, 16'h9, 21'h2, 1'b1, 8'd5, 8'h11, 1'b0, 9'h0, 21'h0);
    rd(A_STAT, 21'h3, "R6", "status frozen");
    rd(A_LEN, 21'h40, "R6", "length frozen");
    rd(A_PAY + 9'd5, 21'hA5, "R6", "payload frozen");
    rd(A_CTRL, 21'd0, "R6", "doorbell stays clear");

    // R8 device status fields
    devFatal = 1'b1; fwHalted = 1'b1; resetNeeded = 2'b10;
    rd(A_DEV, 21'h17, "R8", "device status all set");
    devReady = 1'b0;
    rd(A_DEV, 21'h16, "R8", "device status not ready");
    devReady = 1'b1; devFatal = 1'b0; fwHalted = 1'b0; resetNeeded = 2'b00;

    // R5 second command, success code
    wr(A_OPC, 21'h4102); wr(A_LEN, 21'h8); wr(A_CTRL, 21'd1);
    beCycle(1'b1, 16'h0, 21'h100, 1'b0, 8'd0, 8'h0, 1'b0, 9'h0, 21'h0);
    rd(A_STAT, 21'h0, "R5", "success code");
    rd(A_LEN, 21'h100, "R5", "output length");
    rd(A_CTRL, 21'd0, "R5", "doorbell cleared");
    wr(A_OPC, 21'h0400);
    rd(A_OPC, 21'h0400, "R2", "host access restored");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule